// File: doc/BRIEF.md
# Transactional Cache Tag Tracker

This block keeps the tag and state array of a small set-associative cache and adds two speculation bits to every line: one for lines read inside a transaction and one for lines written inside it. The core opens a transaction, issues load and store lookups, and then closes it with a commit or an explicit abort. A second port carries lookups from other agents. When one of those lookups collides with the transaction's footprint, the transaction is torn down.

Ending a transaction is the only time the array is touched as a whole. A successful close clears every speculation bit in one clock, so the whole write set becomes visible at the same instant. A failed close invalidates every line that carries a speculation bit, also in one clock. Every other operation addresses a single set and way. After any failure the block raises a sticky indication that the critical section must be rerun under a conventional lock, together with a cause code.

A build parameter selects whether a line that carries speculation bits may leave the array. When it may, the bits are reported with the eviction. When it may not, a transactional miss that needs such a victim ends the transaction with a capacity cause.

Top module: `xact_tag_tracker`

## Requirements
- R1: A lookup on the core port produces, one cycle later, a response with a hit flag. On a miss the line is filled into the lowest-numbered invalid way of its set, or, when the set is full, into the way selected by a per-set pointer that advances by one (modulo the way count) on every fill. Address fields: the lowest log2(LINE_BYTES) bits are the byte offset, the next log2(SETS) bits select the set, and the remaining upper bits are the tag.
- R2: While a transaction is active, a load sets the read bit and a store sets the write bit of the line it hits or fills. Outside a transaction no bit is set.
- R3: A foreign read that hits a line with its write bit set, or a foreign write that hits a line with either bit set, while a transaction is active, is a conflict. The snoop response then reports conflict one cycle later, and the transaction ends with cause 1.
- R4: An accepted commit clears every read and write bit in one cycle. Lines stay valid and later hit.
- R5: Any transaction failure invalidates every line that carries a read or write bit, in one cycle. A core lookup issued in the failing cycle does not change the array.
- R6: The cause output is 0 (none), 1 (conflict), 2 (capacity) or 3 (explicit request). It holds until the next accepted begin, which clears it to 0. The retry-under-lock flag rises with any failure and clears on the next accepted begin.
- R7: An abort request while a transaction is active ends it with cause 3.
- R8: When spilling of marked lines is disabled, a transactional miss whose chosen victim is valid and marked ends the transaction with cause 2, performs no fill and reports no eviction.
- R9: Every fill that displaces a valid line reports the line's address (tag, set, zero offset) on the eviction port one cycle later. When spilling is enabled, the line's read and write bits go with it.
- R10: A commit or abort request with no transaction active, or a begin request while one is active, is ignored, and the illegal-request flag is high for exactly the following cycle.
- R11: When a conflict (or an abort request) and a commit arrive in the same cycle, the failure wins and the cause reports it.
- R12: A foreign write that hits a line without causing a conflict invalidates that line. A foreign read changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_begin | input | 1 | Open a transaction |
| tx_commit | input | 1 | Close the transaction successfully |
| tx_abort | input | 1 | Close the transaction as failed |
| acc_valid | input | 1 | Core lookup request |
| acc_store | input | 1 | Core lookup is a store (0 = load) |
| acc_addr | input | ADDR_W | Core lookup byte address |
| snp_valid | input | 1 | Foreign lookup request |
| snp_write | input | 1 | Foreign lookup is a write or invalidate (0 = read) |
| snp_addr | input | ADDR_W | Foreign lookup byte address |
| acc_rsp_valid | output | 1 | Core response present |
| acc_rsp_hit | output | 1 | Core lookup hit |
| snp_rsp_valid | output | 1 | Foreign response present |
| snp_rsp_hit | output | 1 | Foreign lookup hit a valid line |
| snp_rsp_conflict | output | 1 | Foreign lookup collided with the transaction |
| evict_valid | output | 1 | A valid line was displaced |
| evict_addr | output | ADDR_W | Address of the displaced line |
| evict_rd | output | 1 | Read bit carried by the displaced line |
| evict_wr | output | 1 | Write bit carried by the displaced line |
| tx_active | output | 1 | A transaction is open |
| abort_cause | output | 2 | Reason for the last failure |
| retry_locked | output | 1 | Rerun the critical section under a lock |
| illegal_req | output | 1 | One-cycle flag for an ignored request |

## Verification
The bench builds two copies with the default geometry of four sets, two ways and 16-byte lines: one with spilling enabled and one with it disabled, both driven by the same stimulus. Two ways per set mean a third transactional miss in one set already lands on a marked victim, so the capacity abort and the spilled eviction carrying its bits are reached within a few lookups. Four sets and a small tag range keep random traffic full of hits, snoop collisions and same-cycle commit races.

// File: rtl/xt_pkg.sv
package xt_pkg;
   typedef enum logic [1:0] {
      CAUSE_NONE     = 2'd0,
      CAUSE_CONFLICT = 2'd1,
      CAUSE_CAPACITY = 2'd2,
      CAUSE_EXPLICIT = 2'd3
   } cause_t;
endpackage

// File: rtl/xt_lookup.sv
module xt_lookup #(
   parameter int WAYS  = 2,
   parameter int TAG_W = 10,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]            vld,
   input  logic [WAYS-1:0][TAG_W-1:0] tags,
   input  logic [TAG_W-1:0]           tag,
   output logic [WAYS-1:0]            hit_vec,
   output logic                       hit,
   output logic [WAY_W-1:0]           hit_way
);
   genvar gw;
   generate
      for (gw = 0; gw < WAYS; gw++) begin : g_cmp
         assign hit_vec[gw] = vld[gw] && (tags[gw] == tag);
      end
   endgenerate

   assign hit = |hit_vec;

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) hit_way = WAY_W'(w);
      end
   end
endmodule

// File: rtl/xt_victim.sv
module xt_victim #(
   parameter int WAYS = 2,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]  vld,
   input  logic [WAY_W-1:0] ptr,
   output logic [WAY_W-1:0] victim
);
   logic found;

   always_comb begin
      found  = 1'b0;
      victim = ptr;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!vld[w]) begin
            victim = WAY_W'(w);
            found  = 1'b1;
         end
      end
      if (!found) victim = ptr;
   end
endmodule

// File: rtl/xt_txctl.sv
module xt_txctl
   import xt_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   begin_req,
   input  logic   commit_req,
   input  logic   abort_req,
   input  logic   conflict,
   input  logic   capacity,
   output logic   active,
   output cause_t cause,
   output logic   retry,
   output logic   illegal,
   output logic   abort_fire,
   output logic   commit_fire
);
   logic   illegal_n;
   cause_t cause_n;

   assign abort_fire  = active && (conflict || capacity || abort_req);
   assign commit_fire = active && commit_req && !abort_fire;
   assign illegal_n   = (!active && (commit_req || abort_req)) || (active && begin_req);

   always_comb begin
      if (conflict)      cause_n = CAUSE_CONFLICT;
      else if (capacity) cause_n = CAUSE_CAPACITY;
      else               cause_n = CAUSE_EXPLICIT;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         active  <= 1'b0;
         cause   <= CAUSE_NONE;
         retry   <= 1'b0;
         illegal <= 1'b0;
      end else begin
         illegal <= illegal_n;
         if (abort_fire) begin
            active <= 1'b0;
            cause  <= cause_n;
            retry  <= 1'b1;
         end else if (commit_fire) begin
            active <= 1'b0;
         end else if (!active && begin_req) begin
            active <= 1'b1;
            cause  <= CAUSE_NONE;
            retry  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/xact_tag_tracker.sv
module xact_tag_tracker
   import xt_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int LINE_BYTES = 16,
   parameter int SETS       = 4,
   parameter int WAYS       = 2,
   parameter bit HAS_SPILL  = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tx_begin,
   input  logic              tx_commit,
   input  logic              tx_abort,
   input  logic              acc_valid,
   input  logic              acc_store,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              snp_valid,
   input  logic              snp_write,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              acc_rsp_valid,
   output logic              acc_rsp_hit,
   output logic              snp_rsp_valid,
   output logic              snp_rsp_hit,
   output logic              snp_rsp_conflict,
   output logic              evict_valid,
   output logic [ADDR_W-1:0] evict_addr,
   output logic              evict_rd,
   output logic              evict_wr,
   output logic              tx_active,
   output logic [1:0]        abort_cause,
   output logic              retry_locked,
   output logic              illegal_req
);
   localparam int OFF_W = $clog2(LINE_BYTES);
   localparam int IDX_W = $clog2(SETS);
   localparam int WAY_W = $clog2(WAYS);
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

   initial begin : p_param_chk
      assert (WAYS >= 2 && (1 << WAY_W) == WAYS) else $error("WAYS must be a power of two, at least 2");
      assert (SETS >= 2 && (1 << IDX_W) == SETS) else $error("SETS must be a power of two, at least 2");
      assert (LINE_BYTES >= 2 && (1 << OFF_W) == LINE_BYTES) else $error("LINE_BYTES must be a power of two, at least 2");
      assert (TAG_W >= 1) else $error("ADDR_W too small for the geometry");
   end

   // array state
   logic [SETS-1:0][WAYS-1:0]            valid_q, valid_n;
   logic [SETS-1:0][WAYS-1:0]            rd_q, rd_n;
   logic [SETS-1:0][WAYS-1:0]            wr_q, wr_n;
   logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q, tag_n;
   logic [SETS-1:0][WAY_W-1:0]           ptr_q, ptr_n;

   // address split
   logic [IDX_W-1:0] a_idx, s_idx;
   logic [TAG_W-1:0] a_tag, s_tag;
   logic             unused_offsets;

   assign a_idx = acc_addr[OFF_W +: IDX_W];
   assign s_idx = snp_addr[OFF_W +: IDX_W];
   assign a_tag = acc_addr[ADDR_W-1 -: TAG_W];
   assign s_tag = snp_addr[ADDR_W-1 -: TAG_W];
   assign unused_offsets = ^{acc_addr[OFF_W-1:0], snp_addr[OFF_W-1:0]};

   // lookups
   logic [WAYS-1:0]  a_vec, s_vec;
   logic             a_hit, s_hit;
   logic [WAY_W-1:0] a_way, s_way, v_way;

   xt_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_acc_lookup (
      .vld     (valid_q[a_idx]),
      .tags    (tag_q[a_idx]),
      .tag     (a_tag),
      .hit_vec (a_vec),
      .hit     (a_hit),
      .hit_way (a_way)
   );

   xt_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_snp_lookup (
      .vld     (valid_q[s_idx]),
      .tags    (tag_q[s_idx]),
      .tag     (s_tag),
      .hit_vec (s_vec),
      .hit     (s_hit),
      .hit_way (s_way)
   );

   xt_victim #(.WAYS(WAYS)) u_victim (
      .vld    (valid_q[a_idx]),
      .ptr    (ptr_q[a_idx]),
      .victim (v_way)
   );

   // conflict and capacity
   logic s_rd, s_wr, conflict;
   logic v_valid, v_marked, fill_req, cap_need;

   assign s_rd     = rd_q[s_idx][s_way];
   assign s_wr     = wr_q[s_idx][s_way];
   assign conflict = snp_valid && tx_active && s_hit &&
                     (snp_write ? (s_rd || s_wr) : s_wr);

   assign v_valid  = valid_q[a_idx][v_way];
   assign v_marked = v_valid && (rd_q[a_idx][v_way] || wr_q[a_idx][v_way]);
   assign fill_req = acc_valid && !a_hit;

   generate
      if (HAS_SPILL) begin : g_spill
         assign cap_need = 1'b0;
      end else begin : g_nospill
         assign cap_need = fill_req && tx_active && v_marked;
      end
   endgenerate

   // transaction control
   cause_t cause_q;
   logic   abort_fire, commit_fire, acc_ok;

   xt_txctl u_txctl (
      .clk         (clk),
      .rst         (rst),
      .begin_req   (tx_begin),
      .commit_req  (tx_commit),
      .abort_req   (tx_abort),
      .conflict    (conflict),
      .capacity    (cap_need),
      .active      (tx_active),
      .cause       (cause_q),
      .retry       (retry_locked),
      .illegal     (illegal_req),
      .abort_fire  (abort_fire),
      .commit_fire (commit_fire)
   );

   assign abort_cause = cause_q;
   assign acc_ok      = acc_valid && !abort_fire;

   // next state: snoop invalidate, then core update, then broadcasts
   always_comb begin
      valid_n = valid_q;
      rd_n    = rd_q;
      wr_n    = wr_q;
      tag_n   = tag_q;
      ptr_n   = ptr_q;
      if (snp_valid && snp_write && s_hit && !conflict) begin
         valid_n[s_idx][s_way] = 1'b0;
         rd_n[s_idx][s_way]    = 1'b0;
         wr_n[s_idx][s_way]    = 1'b0;
      end
      if (acc_ok) begin
         if (a_hit) begin
            if (tx_active) begin
               if (acc_store) wr_n[a_idx][a_way] = 1'b1;
               else           rd_n[a_idx][a_way] = 1'b1;
            end
         end else begin
            valid_n[a_idx][v_way] = 1'b1;
            tag_n[a_idx][v_way]   = a_tag;
            rd_n[a_idx][v_way]    = tx_active && !acc_store;
            wr_n[a_idx][v_way]    = tx_active && acc_store;
            ptr_n[a_idx]          = ptr_q[a_idx] + WAY_W'(1);
         end
      end
      if (commit_fire) begin
         rd_n = '0;
         wr_n = '0;
      end
      if (abort_fire) begin
         valid_n = valid_n & ~(rd_n | wr_n);
         rd_n    = '0;
         wr_n    = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q          <= '0;
         rd_q             <= '0;
         wr_q             <= '0;
         tag_q            <= '0;
         ptr_q            <= '0;
         acc_rsp_valid    <= 1'b0;
         acc_rsp_hit      <= 1'b0;
         snp_rsp_valid    <= 1'b0;
         snp_rsp_hit      <= 1'b0;
         snp_rsp_conflict <= 1'b0;
         evict_valid      <= 1'b0;
         evict_addr       <= '0;
         evict_rd         <= 1'b0;
         evict_wr         <= 1'b0;
      end else begin
         valid_q          <= valid_n;
         rd_q             <= rd_n;
         wr_q             <= wr_n;
         tag_q            <= tag_n;
         ptr_q            <= ptr_n;
         acc_rsp_valid    <= acc_valid;
         acc_rsp_hit      <= acc_valid && a_hit;
         snp_rsp_valid    <= snp_valid;
         snp_rsp_hit      <= snp_valid && s_hit;
         snp_rsp_conflict <= conflict;
         evict_valid      <= acc_ok && !a_hit && v_valid;
         evict_addr       <= {tag_q[a_idx][v_way], a_idx, {OFF_W{1'b0}}};
         evict_rd         <= rd_q[a_idx][v_way];
         evict_wr         <= wr_q[a_idx][v_way];
      end
   end
endmodule

// File: rtl/xact_tag_tracker_chk.sv
module xact_tag_tracker_chk #(
   parameter int SETS      = 4,
   parameter int WAYS      = 2,
   parameter bit HAS_SPILL = 1'b0
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 tx_active,
   input logic [1:0]           abort_cause,
   input logic                 retry_locked,
   input logic                 snp_rsp_conflict,
   input logic                 evict_valid,
   input logic                 evict_rd,
   input logic                 evict_wr,
   input logic                 commit_fire,
   input logic                 abort_fire,
   input logic [SETS*WAYS-1:0] valid_f,
   input logic [SETS*WAYS-1:0] rd_f,
   input logic [SETS*WAYS-1:0] wr_f,
   input logic [WAYS-1:0]      a_vec,
   input logic [WAYS-1:0]      s_vec
);
   AST_ONE_WAY_HIT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(a_vec) && $onehot0(s_vec)); // R1

   AST_NO_MARK_IDLE: assert property (@(posedge clk) disable iff (rst)
      !tx_active |=> ((rd_f | wr_f) & ~$past(rd_f | wr_f)) == '0); // R2

   AST_CONFLICT_ENDS_TX: assert property (@(posedge clk) disable iff (rst)
      snp_rsp_conflict |-> (!tx_active && abort_cause == 2'd1)); // R3

   AST_COMMIT_FLASH_CLEAR: assert property (@(posedge clk) disable iff (rst)
      commit_fire |=> (rd_f | wr_f) == '0); // R4

   AST_ROLLBACK_INVALIDATES: assert property (@(posedge clk) disable iff (rst)
      abort_fire |=> ((valid_f & $past(rd_f | wr_f)) == '0 && (rd_f | wr_f) == '0)); // R5

   AST_RETRY_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
      retry_locked |-> abort_cause != 2'd0); // R6

   AST_SPILL_CARRIES_BITS: assert property (@(posedge clk) disable iff (rst)
      (evict_valid && (evict_rd || evict_wr)) |-> HAS_SPILL); // R9
endmodule

bind xact_tag_tracker xact_tag_tracker_chk #(
   .SETS(SETS), .WAYS(WAYS), .HAS_SPILL(HAS_SPILL)
) u_chk (
   .clk              (clk),
   .rst              (rst),
   .tx_active        (tx_active),
   .abort_cause      (abort_cause),
   .retry_locked     (retry_locked),
   .snp_rsp_conflict (snp_rsp_conflict),
   .evict_valid      (evict_valid),
   .evict_rd         (evict_rd),
   .evict_wr         (evict_wr),
   .commit_fire      (commit_fire),
   .abort_fire       (abort_fire),
   .valid_f          (valid_q),
   .rd_f             (rd_q),
   .wr_f             (wr_q),
   .a_vec            (a_vec),
   .s_vec            (s_vec)
);

// File: tb/sim_xact_tag_tracker.sv
`timescale 1ns/1ps
module sim_xact_tag_tracker;
   localparam int AW = 16;
   localparam int LB = 16;
   localparam int NS = 4;
   localparam int NW = 2;
   localparam int OFFB = 4;
   localparam int IDXB = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic b_begin = 0, b_commit = 0, b_abort = 0;
   logic b_av = 0, b_ast = 0, b_sv = 0, b_sw = 0;
   logic [AW-1:0] b_aaddr = '0, b_saddr = '0;

   logic          o_arv [2], o_arh [2], o_srv [2], o_srh [2], o_src [2];
   logic          o_ev [2], o_erd [2], o_ewr [2], o_act [2], o_ret [2], o_ill [2];
   logic [AW-1:0] o_eaddr [2];
   logic [1:0]    o_cause [2];

   xact_tag_tracker #(.ADDR_W(AW), .LINE_BYTES(LB), .SETS(NS), .WAYS(NW), .HAS_SPILL(1'b1)) u0 (
      .clk(clk), .rst(rst), .tx_begin(b_begin), .tx_commit(b_commit), .tx_abort(b_abort),
      .acc_valid(b_av), .acc_store(b_ast), .acc_addr(b_aaddr),
      .snp_valid(b_sv), .snp_write(b_sw), .snp_addr(b_saddr),
      .acc_rsp_valid(o_arv[0]), .acc_rsp_hit(o_arh[0]),
      .snp_rsp_valid(o_srv[0]), .snp_rsp_hit(o_srh[0]), .snp_rsp_conflict(o_src[0]),
      .evict_valid(o_ev[0]), .evict_addr(o_eaddr[0]), .evict_rd(o_erd[0]), .evict_wr(o_ewr[0]),
      .tx_active(o_act[0]), .abort_cause(o_cause[0]), .retry_locked(o_ret[0]), .illegal_req(o_ill[0]));

   xact_tag_tracker #(.ADDR_W(AW), .LINE_BYTES(LB), .SETS(NS), .WAYS(NW), .HAS_SPILL(1'b0)) u1 (
      .clk(clk), .rst(rst), .tx_begin(b_begin), .tx_commit(b_commit), .tx_abort(b_abort),
      .acc_valid(b_av), .acc_store(b_ast), .acc_addr(b_aaddr),
      .snp_valid(b_sv), .snp_write(b_sw), .snp_addr(b_saddr),
      .acc_rsp_valid(o_arv[1]), .acc_rsp_hit(o_arh[1]),
      .snp_rsp_valid(o_srv[1]), .snp_rsp_hit(o_srh[1]), .snp_rsp_conflict(o_src[1]),
      .evict_valid(o_ev[1]), .evict_addr(o_eaddr[1]), .evict_rd(o_erd[1]), .evict_wr(o_ewr[1]),
      .tx_active(o_act[1]), .abort_cause(o_cause[1]), .retry_locked(o_ret[1]), .illegal_req(o_ill[1]));

   // behavioural reference, one per instance (index 0 spills, index 1 does not)
   bit m_v [2][NS][NW];
   bit m_r [2][NS][NW];
   bit m_w [2][NS][NW];
   int m_t [2][NS][NW];
   int m_p [2][NS];
   bit m_act [2], m_ret [2];
   int m_cause [2];
   bit e_arv [2], e_arh [2], e_srv [2], e_srh [2], e_src [2], e_ev [2], e_erd [2], e_ewr [2], e_ill [2];
   int e_eaddr [2];

   int vectors = 0;
   int misses = 0;
   string cur_req = "R1";

   task automatic model_step(input int k);
      int si, st, ai, at, sw, aw, vw, sh, ah, found;
      bit conf, cap, abrt, cmt;
      if (rst) begin
         for (int s = 0; s < NS; s++) begin
            m_p[k][s] = 0;
            for (int w = 0; w < NW; w++) begin
               m_v[k][s][w] = 0; m_r[k][s][w] = 0; m_w[k][s][w] = 0; m_t[k][s][w] = 0;
            end
         end
         m_act[k] = 0; m_ret[k] = 0; m_cause[k] = 0;
         e_arv[k] = 0; e_arh[k] = 0; e_srv[k] = 0; e_srh[k] = 0; e_src[k] = 0;
         e_ev[k] = 0; e_erd[k] = 0; e_ewr[k] = 0; e_ill[k] = 0; e_eaddr[k] = 0;
         return;
      end
      si = (int'(b_saddr) >> OFFB) % NS; st = int'(b_saddr) >> (OFFB + IDXB);
      ai = (int'(b_aaddr) >> OFFB) % NS; at = int'(b_aaddr) >> (OFFB + IDXB);
      sh = 0; sw = 0; ah = 0; aw = 0;
      for (int w = 0; w < NW; w++) begin
         if (m_v[k][si][w] && m_t[k][si][w] == st) begin sh = 1; sw = w; end
         if (m_v[k][ai][w] && m_t[k][ai][w] == at) begin ah = 1; aw = w; end
      end
      found = 0; vw = m_p[k][ai];
      for (int w = 0; w < NW; w++) if (!found && !m_v[k][ai][w]) begin found = 1; vw = w; end
      conf = b_sv && m_act[k] && sh != 0 &&
             (b_sw ? (m_r[k][si][sw] || m_w[k][si][sw]) : m_w[k][si][sw]);
      cap  = (k == 1) && b_av && m_act[k] && ah == 0 && m_v[k][ai][vw] &&
             (m_r[k][ai][vw] || m_w[k][ai][vw]);
      abrt = m_act[k] && (conf || cap || b_abort);
      cmt  = m_act[k] && b_commit && !abrt;
      e_ill[k] = (!m_act[k] && (b_commit || b_abort)) || (m_act[k] && b_begin);
      e_arv[k] = b_av; e_arh[k] = b_av && ah != 0;
      e_srv[k] = b_sv; e_srh[k] = b_sv && sh != 0; e_src[k] = conf;
      e_ev[k] = b_av && !abrt && ah == 0 && m_v[k][ai][vw];
      if (e_ev[k]) begin
         e_eaddr[k] = (m_t[k][ai][vw] << (OFFB + IDXB)) | (ai << OFFB);
         e_erd[k] = m_r[k][ai][vw]; e_ewr[k] = m_w[k][ai][vw];
      end
      if (b_sv && b_sw && sh != 0 && !conf) begin
         m_v[k][si][sw] = 0; m_r[k][si][sw] = 0; m_w[k][si][sw] = 0;
      end
      if (b_av && !abrt) begin
         if (ah != 0) begin
            if (m_act[k]) begin
               if (b_ast) m_w[k][ai][aw] = 1; else m_r[k][ai][aw] = 1;
            end
         end else begin
            m_v[k][ai][vw] = 1; m_t[k][ai][vw] = at;
            m_r[k][ai][vw] = m_act[k] && !b_ast; m_w[k][ai][vw] = m_act[k] && b_ast;
            m_p[k][ai] = (m_p[k][ai] + 1) % NW;
         end
      end
      for (int s = 0; s < NS; s++)
         for (int w = 0; w < NW; w++) begin
            if (abrt && (m_r[k][s][w] || m_w[k][s][w])) m_v[k][s][w] = 0;
            if (abrt || cmt) begin m_r[k][s][w] = 0; m_w[k][s][w] = 0; end
         end
      if (abrt) begin
         m_act[k] = 0; m_ret[k] = 1;
         m_cause[k] = conf ? 1 : (cap ? 2 : 3);
      end else if (cmt) begin
         m_act[k] = 0;
      end else if (!m_act[k] && b_begin) begin
         m_act[k] = 1; m_cause[k] = 0; m_ret[k] = 0;
      end
   endtask

   always @(posedge clk) begin
      model_step(0);
      model_step(1);
   end

   task automatic chk(input int k, input string fld, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         misses++;
         $display("FAIL %s u%0d %s actual=%0h expected=%0h at %0t", cur_req, k, fld, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      for (int k = 0; k < 2; k++) begin
         chk(k, "acc_rsp_valid", int'(o_arv[k]), int'(e_arv[k]));
         chk(k, "acc_rsp_hit", int'(o_arh[k]), int'(e_arh[k]));
         chk(k, "snp_rsp_valid", int'(o_srv[k]), int'(e_srv[k]));
         chk(k, "snp_rsp_hit", int'(o_srh[k]), int'(e_srh[k]));
         chk(k, "snp_rsp_conflict", int'(o_src[k]), int'(e_src[k]));
         chk(k, "evict_valid", int'(o_ev[k]), int'(e_ev[k]));
         if (e_ev[k]) begin
            chk(k, "evict_addr", int'(o_eaddr[k]), e_eaddr[k]);
            chk(k, "evict_rd", int'(o_erd[k]), int'(e_erd[k]));
            chk(k, "evict_wr", int'(o_ewr[k]), int'(e_ewr[k]));
         end
         chk(k, "tx_active", int'(o_act[k]), int'(m_act[k]));
         chk(k, "abort_cause", int'(o_cause[k]), m_cause[k]);
         chk(k, "retry_locked", int'(o_ret[k]), int'(m_ret[k]));
         chk(k, "illegal_req", int'(o_ill[k]), int'(e_ill[k]));
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      compare_all();
      b_begin = 0; b_commit = 0; b_abort = 0;
      b_av = 0; b_ast = 0; b_sv = 0; b_sw = 0;
   endtask

   function automatic logic [AW-1:0] mk(input int tg, input int ix);
      return AW'((tg << (OFFB + IDXB)) | (ix << OFFB));
   endfunction

   task automatic ld(input int tg, input int ix);
      b_av = 1; b_ast = 0; b_aaddr = mk(tg, ix); tick();
   endtask
   task automatic st(input int tg, input int ix);
      b_av = 1; b_ast = 1; b_aaddr = mk(tg, ix); tick();
   endtask
   task automatic snp(input bit wr, input int tg, input int ix);
      b_sv = 1; b_sw = wr; b_saddr = mk(tg, ix); tick();
   endtask
   task automatic tbeg();
      b_begin = 1; tick();
   endtask
   task automatic tcom();
      b_commit = 1; tick();
   endtask
   task automatic tabt();
      b_abort = 1; tick();
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
   endtask

   int cycles = 0;
   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         misses++;
         $display("FAIL watchdog expired in %s", cur_req);
         summary();
         $finish;
      end
   end

   initial begin
      // reset state
      cur_req = "R1";
      rst = 1;
      repeat (3) tick();
      rst = 0;
      tick();

      // R1 lookup, fill order, rotation; R9 plain eviction address
      cur_req = "R1";
      ld(1, 0); ld(1, 0); ld(2, 0);
      cur_req = "R9";
      ld(3, 0); ld(2, 0);

      // R2 marking, R3 conflict rule
      cur_req = "R2";
      tbeg(); ld(1, 1); st(2, 1);
      cur_req = "R3";
      snp(0, 1, 1);
      snp(0, 2, 1);
      // R6 sticky cause and retry
      cur_req = "R6";
      tick(); tick();
      // R5 marked lines gone, unmarked kept
      cur_req = "R5";
      ld(1, 1); ld(2, 1); ld(3, 0);

      // R4 commit keeps lines valid, clears bits
      cur_req = "R4";
      tbeg(); st(1, 2); ld(3, 0); tcom();
      ld(1, 2); snp(0, 1, 2); tbeg(); snp(1, 1, 2); tcom();

      // R7 explicit abort
      cur_req = "R7";
      tbeg(); ld(1, 3); tabt(); ld(1, 3);

      // R10 illegal requests
      cur_req = "R10";
      tcom(); tabt(); tbeg(); tbeg(); tcom(); tick();

      // R11 same-cycle races
      cur_req = "R11";
      tbeg(); st(2, 2);
      b_sv = 1; b_sw = 0; b_saddr = mk(2, 2); b_commit = 1; tick();
      tbeg(); ld(1, 2);
      b_abort = 1; b_commit = 1; tick();
      tbeg(); st(5, 2);
      b_sv = 1; b_sw = 1; b_saddr = mk(5, 2); b_av = 1; b_ast = 0; b_aaddr = mk(6, 2); tick();

      // R12 foreign accesses outside a transaction
      cur_req = "R12";
      ld(3, 3); snp(0, 3, 3); ld(3, 3); snp(1, 3, 3); ld(3, 3);

      // R8 capacity abort (no spill) and R9 spilled bits (spill)
      cur_req = "R8";
      tbeg(); ld(5, 1); ld(6, 1); ld(7, 1); ld(8, 1);
      cur_req = "R9";
      st(9, 1); tcom(); ld(5, 1); tick();

      // R11 mixed random traffic over a narrow tag range
      cur_req = "R11";
      for (int i = 0; i < 1500; i++) begin
         int r;
         r = int'($urandom_range(0, 99));
         b_begin  = (r < 8);
         b_commit = (r >= 8 && r < 14);
         b_abort  = (r >= 14 && r < 17);
         b_av     = ($urandom_range(0, 99) < 60);
         b_ast    = $urandom_range(0, 1) == 1;
         b_aaddr  = mk(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
         b_sv     = ($urandom_range(0, 99) < 30);
         b_sw     = $urandom_range(0, 1) == 1;
         b_saddr  = mk(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
         tick();
      end

      summary();
      $finish;
   end
endmodule